// File: doc/BRIEF.md
# ADC Digital Output Formatter

This block is the digital back end of a high-speed 8-bit converter. On each sample period it takes the raw conversion word from the quantiser, along with two flags that mark an input above or below full scale. It carries the word through a fixed two-sample pipeline and forces out-of-range samples to the matching end code. It then presents the word either as straight binary or as two's complement. An in-range flag travels with each word. A chip-enable input, active low, switches off the output drivers.

Beside the data, the block produces a capture strobe that downstream logic can use to latch the bus. Static select inputs set its rate (sample rate or half of it) and how far its rising edge trails the data update. One setting of the delay select switches the strobe driver off.

The block runs on a fast timing clock that is phase-locked to the sample clock. One sample period lasts `TICKS` timing ticks, and each strobe delay step is one tick. High impedance is shown as an output-enable bit beside each driven value. All static selects enter through two-flop synchronisers, so a change takes effect within two ticks.

Top module: `adc_out_fmt`

## Requirements
- R1: A sample period is `TICKS` clock ticks. The sample is captured at the last tick edge of a period. The formatted word captured at sample edge k is shown on `data_out` from sample edge k+2 until edge k+3, and `data_out` only changes at sample edges.
- R2: With `sel_twos` low the word is straight binary: raw code passes unchanged, and mid-scale is 8'h7F.
- R3: With `sel_twos` high the word is the binary word with its most significant bit (bit 7) inverted.
- R4: `in_range` is high when neither range flag was set for the sample shown, including raw codes 8'h00 and 8'hFF. It is low when either flag was set, and it follows the same two-sample delay as its word.
- R5: An overflow sample shows 8'hFF in binary or 8'h7F in two's complement. An underflow sample shows 8'h00 in binary or 8'h80 in two's complement. If both flags are set, overflow wins.
- R6: With `ce_n` high, `data_oe` and `strobe_oe` are both low and `cap_strobe` is low, whatever the coding select. With `ce_n` low, `data_oe` is high.
- R7: With `sel_dly` = 2'b00, `strobe_oe` and `cap_strobe` are low.
- R8: With `sel_dly` = d (1, 2 or 3) and `sel_full_rate` high, `cap_strobe` rises d ticks after every data update and stays high for `TICKS`/2 ticks.
- R9: With `sel_full_rate` low, the strobe period is two sample periods. It rises d ticks after the 2nd, 4th, 6th... data update since reset and stays high for `TICKS` ticks.
- R10: A synchronous reset sets the shown word to binary mid-scale 8'h7F with `in_range` high. The first two data updates after reset still show it. Reset also clears the half-rate divider, so `cap_strobe` is low while reset is held.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, `TICKS` ticks per sample period |
| rst | input | 1 | Synchronous reset, active high |
| raw_code | input | W | Raw conversion word from the quantiser |
| raw_ovr | input | 1 | Sample above positive full scale |
| raw_unr | input | 1 | Sample below negative full scale |
| sel_twos | input | 1 | Static: 1 selects two's complement coding |
| ce_n | input | 1 | Static: chip enable, active low |
| sel_full_rate | input | 1 | Static: 1 strobe at sample rate, 0 at half rate |
| sel_dly | input | 2 | Static: strobe edge delay in ticks, 0 disables strobe |
| data_out | output | W | Formatted output word |
| in_range | output | 1 | High when the shown word was in range |
| data_oe | output | 1 | Drive enable for `data_out` and `in_range` |
| cap_strobe | output | 1 | Capture strobe |
| strobe_oe | output | 1 | Drive enable for `cap_strobe` |

## Verification
On every cycle, the assertions check that the registered word holds steady between sample edges and that an out-of-range word is always an end code. They also check that a disabled strobe never pulses, that chip disable takes the strobe driver down with the data drivers, and that a sample-rate strobe is never high on the tick the data changes. The exact two-sample delay, the coding of each word, the clamp choice when both flags are set, and the strobe phase for each delay and rate setting depend on what went in earlier. Only the bench's scoreboard and strobe model show these, across every combination of the select inputs.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int W       = 8,
  parameter int LATENCY = 2,
  parameter int TICKS   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_code,
  input  logic         raw_ovr,
  input  logic         raw_unr,
  input  logic         sel_twos,
  input  logic         ce_n,
  input  logic         sel_full_rate,
  input  logic [1:0]   sel_dly,
  output logic [W-1:0] data_out,
  output logic         in_range,
  output logic         data_oe,
  output logic         cap_strobe,
  output logic         strobe_oe
);

  localparam int PW   = $clog2(TICKS);
  localparam int HALF = TICKS / 2;
  localparam int SW   = W + 2;
  localparam logic [W-1:0]  MID  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  MSB  = {1'b1, {(W-1){1'b0}}};
  localparam logic [SW-1:0] IDLE = {MID, 2'b00};

  // two-flop synchronisers for the static selects
  logic [4:0] sy_a, sy_b;
  always_ff @(posedge clk) begin
    sy_a <= {sel_dly, sel_full_rate, ce_n, sel_twos};
    sy_b <= sy_a;
  end

  logic       twos_s, cen_s, full_s;
  logic [1:0] dly_s;
  assign twos_s = sy_b[0];
  assign cen_s  = sy_b[1];
  assign full_s = sy_b[2];
  assign dly_s  = sy_b[4:3];

  // sample phase and half-rate divider
  logic [PW-1:0] ph;
  logic          half;
  logic          smp;
  assign smp = (ph == PW'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      half <= 1'b0;
    end else begin
      ph <= smp ? '0 : ph + 1'b1;
      if (smp) half <= ~half;
    end
  end

  // sample pipeline: {code, ovr, unr}
  logic [SW-1:0] stg [LATENCY];

  for (genvar i = 0; i < LATENCY; i++) begin : g_stage
    if (i == 0) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst)      stg[0] <= IDLE;
        else if (smp) stg[0] <= {raw_code, raw_ovr, raw_unr};
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)      stg[i] <= IDLE;
        else if (smp) stg[i] <= stg[i-1];
      end
    end
  end

  logic [W-1:0] last_code, bin_nx, bin_q;
  logic         last_ovr, last_unr, ir_q;
  assign {last_code, last_ovr, last_unr} = stg[LATENCY-1];
  assign bin_nx = last_ovr ? '1 : (last_unr ? '0 : last_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= MID;
      ir_q  <= 1'b1;
    end else if (smp) begin
      bin_q <= bin_nx;
      ir_q  <= ~(last_ovr | last_unr);
    end
  end

  assign data_out = twos_s ? (bin_q ^ MSB) : bin_q;
  assign in_range = ir_q;
  assign data_oe  = ~cen_s;

  // capture strobe window
  logic [PW+1:0] pos, d_lo, win;
  logic          stb_on;
  always_comb begin
    pos    = (PW+2)'(ph) + ((!full_s && half) ? (PW+2)'(TICKS) : '0);
    d_lo   = (PW+2)'(dly_s);
    win    = full_s ? (PW+2)'(HALF) : (PW+2)'(TICKS);
    stb_on = (pos >= d_lo) && (pos < d_lo + win);
  end

  assign strobe_oe  = ~cen_s && (dly_s != 2'b00);
  assign cap_strobe = strobe_oe && stb_on;

endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int W     = 8,
  parameter int TICKS = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [W-1:0]             bin_q,
  input logic                     in_range,
  input logic                     data_oe,
  input logic                     cap_strobe,
  input logic                     strobe_oe,
  input logic [$clog2(TICKS)-1:0] ph,
  input logic                     full_s
);

  assert_word_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (ph != ($clog2(TICKS))'(TICKS - 1)) |=> ($stable(bin_q) && $stable(in_range)));

  assert_clamp_end_R5: assert property (@(posedge clk) disable iff (rst)
    !in_range |-> (bin_q == '0 || bin_q == '1));

  assert_chip_off_R6: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> !strobe_oe);

  assert_strobe_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe_oe |-> !cap_strobe);

  assert_edge_after_data_R8: assert property (@(posedge clk) disable iff (rst)
    (full_s && ph == '0) |-> !cap_strobe);

endmodule

bind adc_out_fmt adc_out_fmt_chk #(.W(W), .TICKS(TICKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bin_q      (bin_q),
  .in_range   (in_range),
  .data_oe    (data_oe),
  .cap_strobe (cap_strobe),
  .strobe_oe  (strobe_oe),
  .ph         (ph),
  .full_s     (full_s)
);

// File: tb/adc_out_fmt_bench.sv
`timescale 1ns/1ps
module adc_out_fmt_bench;
  localparam int W   = 8;
  localparam int N   = 8;
  localparam int LAT = 2;
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] raw_code = '0;
  logic         raw_ovr = 1'b0, raw_unr = 1'b0;
  logic         sel_twos = 1'b0, ce_n = 1'b0, sel_full_rate = 1'b1;
  logic [1:0]   sel_dly = 2'b01;
  logic [W-1:0] data_out;
  logic         in_range, data_oe, cap_strobe, strobe_oe;

  always #2.5 clk = ~clk;

  adc_out_fmt #(.W(W), .LATENCY(LAT), .TICKS(N)) u_adc_out_fmt (
    .clk(clk), .rst(rst), .raw_code(raw_code), .raw_ovr(raw_ovr), .raw_unr(raw_unr),
    .sel_twos(sel_twos), .ce_n(ce_n), .sel_full_rate(sel_full_rate), .sel_dly(sel_dly),
    .data_out(data_out), .in_range(in_range), .data_oe(data_oe),
    .cap_strobe(cap_strobe), .strobe_oe(strobe_oe));

  typedef struct {
    logic [W-1:0] code;
    logic         ovr;
    logic         unr;
    int           due;
  } item_t;

  item_t sb[$];
  int    checks = 0, errors = 0;
  int    tcnt = 0, chg_at = 0, sidx = 0, cur_j = 0;
  event  smp_done;

  always @(posedge clk) begin
    if (rst) tcnt <= 0;
    else     tcnt <= tcnt + 1;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] c, input logic o,
                                            input logic u, input logic tw);
    logic [W-1:0] b;
    b = o ? '1 : (u ? '0 : c);
    return tw ? (b ^ MSB) : b;
  endfunction

  task automatic set_statics(input logic tw, input logic fr, input logic [1:0] dl, input logic cn);
    sel_twos = tw; sel_full_rate = fr; sel_dly = dl; ce_n = cn;
    chg_at = tcnt;
  endtask

  // driver: called at a negedge, returns at the negedge after the sample edge
  task automatic drive_sample(input logic [W-1:0] c, input logic o, input logic u);
    item_t it;
    raw_code = c; raw_ovr = o; raw_unr = u;
    repeat (N) @(posedge clk);
    it.code = c; it.ovr = o; it.unr = u; it.due = sidx + LAT;
    sb.push_back(it);
    cur_j = sidx;
    sidx++;
    -> smp_done;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t it;
      string tag;
      @(smp_done);
      #1;
      if (sb.size() > 0 && sb[0].due == cur_j) begin
        it  = sb.pop_front();
        tag = (it.ovr || it.unr) ? "R5" : (sel_twos ? "R3" : "R2");
      end else begin
        it.code = 8'h7F; it.ovr = 1'b0; it.unr = 1'b0; it.due = cur_j;
        tag = "R10";
      end
      check({tag, " R1"}, "data_out", data_out, exp_word(it.code, it.ovr, it.unr, sel_twos));
      check("R4", "in_range", in_range, !(it.ovr || it.unr));
      check("R6", "data_oe", data_oe, !ce_n);
    end
  end

  // strobe model, checked every tick once the selects have settled
  initial begin
    forever begin
      int ph, hf, pos, win, d;
      logic s_oe, s_exp;
      string tag;
      @(posedge clk);
      #1;
      if (!rst && (tcnt - chg_at) >= 3) begin
        ph    = tcnt % N;
        hf    = (tcnt / N) % 2;
        d     = int'(sel_dly);
        pos   = sel_full_rate ? ph : hf * N + ph;
        win   = sel_full_rate ? N / 2 : N;
        s_oe  = !ce_n && (sel_dly != 2'b00);
        s_exp = s_oe && (pos >= d) && (pos < d + win);
        tag   = ce_n ? "R6" : (sel_dly == 2'b00 ? "R7" : (sel_full_rate ? "R8" : "R9"));
        check(tag, "strobe_oe", strobe_oe, s_oe);
        check(tag, "cap_strobe", cap_strobe, s_exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10", "data_out reset", data_out, 8'h7F);
    check("R10", "in_range reset", in_range, 1);
    check("R10", "cap_strobe reset", cap_strobe, 0);
    rst = 1'b0;
    // R4 boundary codes stay in range, R5 clamps and overflow priority
    drive_sample(8'h00, 1'b0, 1'b0);
    drive_sample(8'hFF, 1'b0, 1'b0);
    drive_sample(8'h55, 1'b1, 1'b0);
    drive_sample(8'h55, 1'b0, 1'b1);
    drive_sample(8'h12, 1'b1, 1'b1);
    drive_sample(8'h7F, 1'b0, 1'b0);
    // every combination of the select inputs
    for (int cn = 0; cn < 2; cn++)
      for (int tw = 0; tw < 2; tw++)
        for (int fr = 0; fr < 2; fr++)
          for (int dl = 0; dl < 4; dl++) begin
            set_statics(tw[0], fr[0], dl[1:0], cn[0]);
            for (int k = 0; k < 10; k++) begin
              int r;
              r = $urandom % 8;
              drive_sample(W'($urandom), (r == 0) || (r == 2), (r == 1) || (r == 2));
            end
          end
    // R3/R5 directed in two's complement
    set_statics(1'b1, 1'b1, 2'b10, 1'b0);
    drive_sample(8'h00, 1'b0, 1'b1);
    drive_sample(8'hAA, 1'b1, 1'b0);
    drive_sample(8'h7F, 1'b0, 1'b0);
    repeat (LAT + 1) drive_sample(8'h40, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule